// File: doc/BRIEF.md
# Timestamp Capture Queue Pair

This block buffers packet timestamps for a host processor. It has two independent first-in first-out queues, one for transmit and one for receive. Capture logic elsewhere in the chip pushes one 128-bit timestamp record into either queue with a single-cycle strobe. The host reaches the block through a simple 32-bit register bus. Writes take effect on the clock edge. Reads are combinational from the address.

To drain a queue, the host reads that queue's status word to learn how many records are waiting. For each record it then runs a short sequence. First it writes zero to the control word, which lowers the completion flags. Then it writes the pop bit of the queue. Next it polls the control word until the matching completion bit reads back as one. Finally it reads the popped record from a per-queue holding register as four 32-bit words, most significant first.

Each queue also has its own clear bit. While that bit is held at one, the queue stays empty and ignores pushes. A push into a full queue is dropped and sets a sticky overflow flag, which only a clear removes.

Top module: `tsq_pair`

## Requirements
- R1: After reset, the control word, both status words and every holding-register word read as zero.
- R2: The status word at 0x44 (receive) and 0x48 (transmit) holds that queue's record count in bits [4:0] and its overflow flag in bit 16. The two queues count independently.
- R3: Records leave each queue in the order they were pushed. The receive holding register is read at 0x60, 0x64, 0x68 and 0x6C, and the transmit one at 0x70, 0x74, 0x78 and 0x7C. In each group the lowest address gives bits [127:96] and the highest gives bits [31:0].
- R4: A write to the control word at 0x40 clears both completion bits. A write with bit 0 (transmit) or bit 2 (receive) set starts a pop. The matching completion bit reads 0 one cycle after the write and 1 from the second cycle on. The count drops by one at the same moment.
- R5: Each queue holds 16 records. A push into a full queue is dropped and sets that queue's overflow flag. The flag stays set until the queue is cleared.
- R6: A pop of an empty queue still sets the completion bit. It leaves the holding register and the count unchanged.
- R7: A push and a pop that take effect on the same clock edge in one non-empty queue leave its count unchanged.
- R8: Control bit 1 clears the transmit queue and bit 3 clears the receive queue. Both bits read back as written. While a clear bit is set, that queue's count and overflow flag read zero and pushes into it are ignored. The other queue is not affected. Writing both bits clears both queues.
- R9: A queue's count never exceeds 16. Apart from a clear, it changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| tx_push | input | 1 | Push strobe for the transmit queue |
| tx_stamp | input | 128 | Transmit record to push |
| rx_push | input | 1 | Push strobe for the receive queue |
| rx_stamp | input | 128 | Receive record to push |

## Verification
The assertions assume that each push strobe lasts exactly one cycle per record. They also assume that the host starts a new pop only after the previous one has reported completion. Otherwise the two-cycle link between a pop request and a rising completion flag would be ambiguous. The bench keeps within these limits. Its push task raises a strobe for a single cycle, and its pop task always polls for completion before it issues the next command. The single exception is the same-edge scenario, which deliberately lines a push up with the pop edge of a non-empty queue.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    // register byte addresses
    localparam logic [7:0] ADDR_CTRL    = 8'h40;
    localparam logic [7:0] ADDR_STAT_RX = 8'h44;
    localparam logic [7:0] ADDR_STAT_TX = 8'h48;
    localparam logic [7:0] ADDR_HOLD_RX = 8'h60;
    localparam logic [7:0] ADDR_HOLD_TX = 8'h70;
    // queue indices: control bits 2*i (pop) and 2*i+1 (clear)
    localparam int Q_TX  = 0;
    localparam int Q_RX  = 1;
    localparam int NUM_Q = 2;
    // overflow flag position in a status word
    localparam int OVF_BIT = 16;
endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
    parameter int DEPTH = 16,
    parameter int REC_W = 128,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pop_start,
    input  logic             done_clr,
    input  logic             push,
    input  logic [REC_W-1:0] push_rec,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             done,
    output logic [REC_W-1:0] hold
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             pend;
        logic             done;
        logic [REC_W-1:0] hold;
    } fifo_st_t;

    fifo_st_t         st_q, st_d;
    logic [REC_W-1:0] mem_q [DEPTH];
    logic             full, empty, fire, take, accept, wr_en;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full   = (st_q.cnt == CNT_W'(DEPTH));
        empty  = (st_q.cnt == '0);
        fire   = st_q.pend;
        take   = fire && !empty;
        accept = push && (!full || take);
        wr_en  = accept && !clr;

        st_d = st_q;
        if (clr) begin
            st_d.wr   = '0;
            st_d.rd   = '0;
            st_d.cnt  = '0;
            st_d.ovf  = 1'b0;
            st_d.pend = 1'b0;
            st_d.done = 1'b0;
        end else begin
            st_d.pend = pop_start;
            if (done_clr) st_d.done = 1'b0;
            if (fire)     st_d.done = 1'b1;
            if (take) begin
                st_d.hold = mem_q[st_q.rd];
                st_d.rd   = bump(st_q.rd);
            end
            if (accept)         st_d.wr  = bump(st_q.wr);
            if (push && !accept) st_d.ovf = 1'b1;
            case ({accept, take})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.wr] <= push_rec;
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;
    assign done  = st_q.done;
    assign hold  = st_q.hold;
endmodule

// File: rtl/tsq_regs.sv
module tsq_regs
    import tsq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int REC_W  = 128,
    parameter int CNT_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    input  logic [NUM_Q-1:0][CNT_W-1:0]  q_cnt,
    input  logic [NUM_Q-1:0]             q_ovf,
    input  logic [NUM_Q-1:0]             q_done,
    input  logic [NUM_Q-1:0][REC_W-1:0]  q_hold,
    output logic [NUM_Q-1:0]             q_clr,
    output logic [NUM_Q-1:0]             q_pop,
    output logic [NUM_Q-1:0]             q_done_clr
);
    localparam int WORDS = REC_W / DATA_W;

    typedef struct packed {
        logic [NUM_Q-1:0] clr;
    } regs_st_t;

    regs_st_t st_q, st_d;
    logic     ctrl_hit;

    function automatic logic [ADDR_W-1:0] stat_addr(input int q);
        return (q == Q_RX) ? ADDR_W'(ADDR_STAT_RX) : ADDR_W'(ADDR_STAT_TX);
    endfunction

    function automatic logic [ADDR_W-1:0] hold_addr(input int q, input int w);
        return ((q == Q_RX) ? ADDR_W'(ADDR_HOLD_RX) : ADDR_W'(ADDR_HOLD_TX)) + ADDR_W'(4 * w);
    endfunction

    always_comb begin
        ctrl_hit = wr_en && (addr == ADDR_W'(ADDR_CTRL));
        st_d     = st_q;
        for (int i = 0; i < NUM_Q; i++) begin
            if (ctrl_hit) st_d.clr[i] = wdata[2*i+1];
            q_pop[i]      = ctrl_hit && wdata[2*i];
            q_done_clr[i] = ctrl_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_clr = st_q.clr;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            for (int i = 0; i < NUM_Q; i++) begin
                rdata[2*i]   = q_done[i];
                rdata[2*i+1] = st_q.clr[i];
            end
        end
        for (int i = 0; i < NUM_Q; i++) begin
            if (addr == stat_addr(i)) begin
                rdata[CNT_W-1:0] = q_cnt[i];
                rdata[OVF_BIT]   = q_ovf[i];
            end
            for (int w = 0; w < WORDS; w++) begin
                if (addr == hold_addr(i, w))
                    rdata = q_hold[i][REC_W-1-w*DATA_W -: DATA_W];
            end
        end
    end
endmodule

// File: rtl/tsq_pair.sv
module tsq_pair
    import tsq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int REC_W  = 128,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_push,
    input  logic [REC_W-1:0]  tx_stamp,
    input  logic              rx_push,
    input  logic [REC_W-1:0]  rx_stamp
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NUM_Q-1:0]            q_push;
    logic [NUM_Q-1:0][REC_W-1:0] q_rec;
    logic [NUM_Q-1:0][CNT_W-1:0] q_cnt;
    logic [NUM_Q-1:0]            q_ovf, q_done, q_clr, q_pop, q_done_clr;
    logic [NUM_Q-1:0][REC_W-1:0] q_hold;

    always_comb begin
        q_push[Q_TX] = tx_push;
        q_push[Q_RX] = rx_push;
        q_rec[Q_TX]  = tx_stamp;
        q_rec[Q_RX]  = rx_stamp;
    end

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        tsq_fifo #(
            .DEPTH (DEPTH),
            .REC_W (REC_W),
            .CNT_W (CNT_W)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (q_clr[i]),
            .pop_start (q_pop[i]),
            .done_clr  (q_done_clr[i]),
            .push      (q_push[i]),
            .push_rec  (q_rec[i]),
            .count     (q_cnt[i]),
            .ovf       (q_ovf[i]),
            .done      (q_done[i]),
            .hold      (q_hold[i])
        );
    end

    tsq_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REC_W  (REC_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .q_cnt      (q_cnt),
        .q_ovf      (q_ovf),
        .q_done     (q_done),
        .q_hold     (q_hold),
        .q_clr      (q_clr),
        .q_pop      (q_pop),
        .q_done_clr (q_done_clr)
    );
endmodule

// File: rtl/tsq_chk.sv
module tsq_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             pop_start,
    input logic             push,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             done
);
    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (int'(cnt) == int'($past(cnt)) || int'(cnt) == int'($past(cnt)) + 1
                  || int'(cnt) + 1 == int'($past(cnt))));

    // R8
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf && !done));

    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pop_start, 2));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R5
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(push) && $past(cnt) == CNT_W'(DEPTH)));

    // R7
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pop_start) && !$past(clr) && push && !clr && cnt != '0) |=> cnt == $past(cnt));
endmodule

// queue index 0 is transmit, 1 is receive
bind tsq_pair tsq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk_tx (
    .clk(clk), .rst_n(rst_n), .clr(q_clr[0]), .pop_start(q_pop[0]),
    .push(q_push[0]), .cnt(q_cnt[0]), .ovf(q_ovf[0]), .done(q_done[0]));

bind tsq_pair tsq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk_rx (
    .clk(clk), .rst_n(rst_n), .clr(q_clr[1]), .pop_start(q_pop[1]),
    .push(q_push[1]), .cnt(q_cnt[1]), .ovf(q_ovf[1]), .done(q_done[1]));

// File: tb/tsq_pair_tb.sv
module tsq_pair_tb;
    localparam logic [7:0] A_CTRL = 8'h40, A_SRX = 8'h44, A_STX = 8'h48,
                           A_HRX = 8'h60, A_HTX = 8'h70;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         tx_push = 1'b0, rx_push = 1'b0;
    logic [127:0] tx_stamp = '0, rx_stamp = '0;

    int checks = 0;
    int bad    = 0;

    always #2.5 clk = ~clk;

    tsq_pair u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_stamp(tx_stamp),
        .rx_push(rx_push), .rx_stamp(rx_stamp));

    function automatic logic [127:0] mk(input int q, input int n);
        return {8'hA0 + 8'(q), 24'(n), 32'hC0DE_0000 + 32'(n), ~32'(n), 32'(n * 7 + q)};
    endfunction

    function automatic logic [31:0] stat(input int cnt, input bit ovf);
        return (32'(ovf) << 16) | 32'(cnt);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input int q, input logic [127:0] rec);
        @(negedge clk);
        if (q == 1) begin rx_push = 1'b1; rx_stamp = rec; end
        else        begin tx_push = 1'b1; tx_stamp = rec; end
        @(negedge clk);
        rx_push = 1'b0; tx_push = 1'b0;
    endtask

    task automatic read_hold(input int q, output logic [127:0] rec);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            bus_rd((q == 1 ? A_HRX : A_HTX) + 8'(4 * i), w);
            rec[127 - 32 * i -: 32] = w;
        end
    endtask

    // pop with exact timing checks of the completion bit (R4)
    task automatic pop(input int q, output logic [127:0] rec);
        logic [31:0] c;
        int bitn = (q == 1) ? 2 : 0;
        bus_wr(A_CTRL, 32'h0);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'(1) << bitn;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 c = reg_rdata;
        chk("R4 done low one cycle after pop", 32'(c[bitn]), 32'h0);
        bus_rd(A_CTRL, c);
        chk("R4 done high two cycles after pop", 32'(c[bitn]), 32'h1);
        read_hold(q, rec);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [127:0] r;
        bus_rd(A_CTRL, d); chk("R1 ctrl reset", d, 32'h0);
        bus_rd(A_SRX, d);  chk("R1 rx status reset", d, 32'h0);
        bus_rd(A_STX, d);  chk("R1 tx status reset", d, 32'h0);
        read_hold(1, r);   chk128("R1 rx hold reset", r, '0);
        read_hold(0, r);   chk128("R1 tx hold reset", r, '0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        logic [127:0] r;
        for (int n = 0; n < 3; n++) push(1, mk(1, n));
        for (int n = 0; n < 2; n++) push(0, mk(0, n));
        bus_rd(A_SRX, d); chk("R2 rx count", d, stat(3, 0));
        bus_rd(A_STX, d); chk("R2 tx count", d, stat(2, 0));
        pop(1, r); chk128("R3 rx first record", r, mk(1, 0));
        bus_rd(A_SRX, d); chk("R4 rx count after pop", d, stat(2, 0));
        pop(0, r); chk128("R3 tx first record", r, mk(0, 0));
        pop(1, r); chk128("R3 rx second record", r, mk(1, 1));
        pop(1, r); chk128("R3 rx third record", r, mk(1, 2));
        pop(0, r); chk128("R3 tx second record", r, mk(0, 1));
        bus_wr(A_CTRL, 32'h0);
        bus_rd(A_CTRL, d); chk("R4 zero write clears done", d, 32'h0);
        bus_rd(A_SRX, d); chk("R2 rx drained", d, stat(0, 0));
    endtask

    task automatic t_empty_pop();
        logic [31:0] d;
        logic [127:0] r;
        pop(1, r); chk128("R6 empty pop keeps hold", r, mk(1, 2));
        bus_rd(A_SRX, d); chk("R6 empty pop count", d, stat(0, 0));
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        logic [127:0] r;
        for (int n = 0; n < 17; n++) push(0, mk(0, 100 + n));
        bus_rd(A_STX, d); chk("R5 full with overflow", d, stat(16, 1));
        bus_rd(A_SRX, d); chk("R2 rx unaffected by tx overflow", d, stat(0, 0));
        pop(0, r); chk128("R5 oldest kept", r, mk(0, 100));
        for (int n = 1; n < 16; n++) pop(0, r);
        chk128("R5 17th push dropped", r, mk(0, 115));
        bus_rd(A_STX, d); chk("R5 overflow sticky", d, stat(0, 1));
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        logic [127:0] r;
        push(1, mk(1, 20));
        push(1, mk(1, 21));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wdata = 32'h4;
        @(negedge clk);
        reg_wr = 1'b0; rx_push = 1'b1; rx_stamp = mk(1, 22);
        @(negedge clk);
        rx_push = 1'b0;
        bus_rd(A_SRX, d); chk("R7 push+pop count unchanged", d, stat(2, 0));
        read_hold(1, r); chk128("R7 popped oldest", r, mk(1, 20));
        pop(1, r); chk128("R7 next record", r, mk(1, 21));
        pop(1, r); chk128("R7 pushed record kept", r, mk(1, 22));
    endtask

    task automatic t_clear();
        logic [31:0] d;
        push(1, mk(1, 30));
        push(1, mk(1, 31));
        bus_wr(A_CTRL, 32'h2);
        @(negedge clk);
        bus_rd(A_CTRL, d); chk("R8 tx clear bit reads back", d, 32'h2);
        bus_rd(A_STX, d);  chk("R8 tx cleared with overflow", d, stat(0, 0));
        bus_rd(A_SRX, d);  chk("R8 rx untouched by tx clear", d, stat(2, 0));
        push(0, mk(0, 40));
        bus_rd(A_STX, d);  chk("R8 push ignored while clear held", d, stat(0, 0));
        bus_wr(A_CTRL, 32'h0);
        push(0, mk(0, 41));
        bus_rd(A_STX, d);  chk("R8 push accepted after release", d, stat(1, 0));
        bus_wr(A_CTRL, 32'hA);
        @(negedge clk);
        bus_rd(A_STX, d);  chk("R8 both clear tx", d, stat(0, 0));
        bus_rd(A_SRX, d);  chk("R8 both clear rx", d, stat(0, 0));
        bus_wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_empty_pop();
        t_overflow();
        t_same_cycle();
        t_clear();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule